// File: doc/BRIEF.md
# RAM-Based Sequential Pattern Generator

This block replays stored byte patterns. A 256-word by 8-bit pattern store is loaded by the host, one location per write cycle. The host also programs a start address and chooses the advance source. An address register walks the store from the start address and places one stored word on the output at each advance tick.

The advance tick comes from one of two sources. In internal mode the tick fires on every system clock cycle. In external mode an asynchronous clock input is synchronised, and each of its rising edges becomes a one-cycle advance pulse. Raising the enable reloads the address register from the start address. Lowering it freezes the output on the last word shown.

Top module: `pattern_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `pat_out` is 0, the start address is 0, internal mode is selected and the generator is idle.
- R2: Every one of the 256 store locations can be written through `host_wr_en`/`host_wr_addr`/`host_wr_data`, and a fetch in any later cycle returns the written byte.
- R3: On the first clock edge at which `gen_en` is seen high after being low or after reset, the address register loads the start address and `pat_out` shows the stored word at that address after the same edge. Any tick in that cycle is not used.
- R4: While running in internal mode, each further clock edge with `gen_en` high adds one to the address and shows that location's word.
- R5: The address wraps from 255 to 0 and keeps counting up.
- R6: In external mode, each rising edge of `ext_clk` gives exactly one advance. The edge passes through two synchroniser flops and one edge-detect flop, so the advance lands on the third system clock edge after `ext_clk` is first sampled high.
- R7: While `gen_en` is low, `pat_out` and the address hold their values, and neither ticks nor host writes change them.
- R8: A start address written with `host_start_wr` is used only at the next enable. A start write in the same cycle as the enable does not affect that load, which uses the previous start address.
- R9: A store write to the location being fetched in the same cycle does not change that fetch. `pat_out` takes the old contents, and the new byte appears on later visits.
- R10: `host_mode_wr` stores `host_mode_ext` as the source select (0 = internal clock, 1 = external clock). The new mode applies to ticks from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Write strobe for the pattern store |
| host_wr_addr | input | 8 | Store location to write |
| host_wr_data | input | 8 | Byte to store |
| host_start_wr | input | 1 | Write strobe for the start address |
| host_start_addr | input | 8 | New start address |
| host_mode_wr | input | 1 | Write strobe for the source select |
| host_mode_ext | input | 1 | Source select value: 0 internal, 1 external |
| gen_en | input | 1 | Generator enable; a rising level reloads the start address |
| ext_clk | input | 1 | Asynchronous external advance clock |
| pat_out | output | 8 | Pattern currently presented |

## Verification
Two collisions can fall in the same cycle. The first is a host store write and the fetch of the same location. The second is a start-address write and the enable edge that loads the start address. The bench provokes the first by aiming a write at the address the model says will be fetched next. It provokes the second by asserting the start write together with the first high cycle of `gen_en`. In both cases a behavioural reference, which applies host writes only after it has computed the fetch, predicts `pat_out` on every clock, and any difference is reported against R9 or R8.

// File: rtl/pgen_pkg.sv
// Shared sizing for the pattern generator.
// Assumes: byte-wide patterns and a power-of-two store depth.
package pgen_pkg;
    parameter int unsigned PG_ADDR_W = 8;
    parameter int unsigned PG_DATA_W = 8;
    parameter int unsigned PG_SYNC_STAGES = 2;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } pg_src_e;
endpackage

// File: rtl/pgen_edge_sync.sv
// Brings an asynchronous clock into the system domain and emits one
// single-cycle pulse per rising edge.
// Assumes: the input stays high and low for at least two system cycles each.
module pgen_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Synchroniser chain followed by one edge-detect history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // Pulse when the synchronised level is high and its history is low.
    always_comb begin
        rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/pgen_store.sv
// Pattern store: one synchronous write port and one combinational read port.
// Assumes: a read in the same cycle as a write to that location returns old data.
module pgen_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Host write into the addressed cell.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Read of the current cell contents.
    always_comb begin
        rd_data = cells[rd_addr];
    end
endmodule

// File: rtl/pgen_addr_seq.sv
// Address register that reloads on an enable edge and counts on ticks.
// Assumes: the address width gives a natural wrap from the top to zero.
module pgen_addr_seq #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          tick,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] next_addr,
    output logic          load,
    output logic [AW-1:0] cur_addr,
    output logic          running
);
    logic [AW-1:0] addr_q;
    logic          run_q;

    // Choose the next address: reload on enable edge, increment on tick.
    always_comb begin
        next_addr = addr_q;
        load      = 1'b0;
        if (run_req && !run_q) begin
            next_addr = start_addr;
            load      = 1'b1;
        end else if (run_req && tick) begin
            next_addr = addr_q + 1'b1;
            load      = 1'b1;
        end
    end

    // Hold the address and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            run_q  <= 1'b0;
        end else begin
            run_q <= run_req;
            if (load) begin
                addr_q <= next_addr;
            end
        end
    end

    assign cur_addr = addr_q;
    assign running  = run_q;
endmodule

// File: rtl/pattern_sequencer.sv
// Top level of the pattern generator: host registers, tick source
// selection, address sequencing and the output pattern register.
// Assumes: host inputs are synchronous to clk; only ext_clk is asynchronous.
module pattern_sequencer
    import pgen_pkg::*;
#(
    parameter int unsigned AW = PG_ADDR_W,
    parameter int unsigned DW = PG_DATA_W,
    parameter int unsigned SYNC_STAGES = PG_SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_start_wr,
    input  logic [AW-1:0] host_start_addr,
    input  logic          host_mode_wr,
    input  logic          host_mode_ext,
    input  logic          gen_en,
    input  logic          ext_clk,
    output logic [DW-1:0] pat_out
);
    logic [AW-1:0] start_q;
    pg_src_e       src_q;
    logic          ext_pulse;
    logic          adv_tick;
    logic [AW-1:0] fetch_addr;
    logic          fetch_load;
    logic [AW-1:0] seq_addr;
    logic          seq_running;
    logic [DW-1:0] fetch_data;
    logic [DW-1:0] out_q;

    // Host-programmed start address and source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            src_q   <= SRC_INTERNAL;
        end else begin
            if (host_start_wr) begin
                start_q <= host_start_addr;
            end
            if (host_mode_wr) begin
                src_q <= pg_src_e'(host_mode_ext);
            end
        end
    end

    pgen_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) u_ext_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (ext_clk),
        .rise_pulse(ext_pulse)
    );

    // Advance tick: every cycle internally, or one per external edge.
    always_comb begin
        adv_tick = (src_q == SRC_EXTERNAL) ? ext_pulse : 1'b1;
    end

    pgen_addr_seq #(
        .AW(AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (gen_en),
        .tick      (adv_tick),
        .start_addr(start_q),
        .next_addr (fetch_addr),
        .load      (fetch_load),
        .cur_addr  (seq_addr),
        .running   (seq_running)
    );

    pgen_store #(
        .AW(AW),
        .DW(DW)
    ) u_store (
        .clk    (clk),
        .wr_en  (host_wr_en),
        .wr_addr(host_wr_addr),
        .wr_data(host_wr_data),
        .rd_addr(fetch_addr),
        .rd_data(fetch_data)
    );

    // Output register, updated whenever a new address is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (fetch_load) begin
            out_q <= fetch_data;
        end
    end

    assign pat_out = out_q;
endmodule

// File: rtl/pgen_checker.sv
// Temporal checks for pattern_sequencer, attached with bind.
// Assumes: internal names of the top level as bound below.
module pgen_checker #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gen_en,
    input logic [DW-1:0] pat_out,
    input logic [AW-1:0] seq_addr,
    input logic          seq_running,
    input logic [AW-1:0] start_q,
    input logic          adv_tick,
    input logic          ext_pulse
);
    // R3: an enable edge loads the start address.
    assert_load_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !seq_running) |=> (seq_addr == $past(start_q)));

    // R4 and R5: a tick while running adds one, modulo the depth.
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && seq_running && adv_tick) |=> (seq_addr == AW'($past(seq_addr) + 1'b1)));

    // R6: the external advance is a single-cycle pulse.
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pulse |=> !ext_pulse);

    // R7: while disabled the output is frozen.
    assert_out_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> $stable(pat_out));

    // R7: while disabled the address is frozen.
    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> $stable(seq_addr));
endmodule

bind pattern_sequencer pgen_checker #(
    .AW(AW),
    .DW(DW)
) u_pgen_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .pat_out    (pat_out),
    .seq_addr   (seq_addr),
    .seq_running(seq_running),
    .start_q    (start_q),
    .adv_tick   (adv_tick),
    .ext_pulse  (ext_pulse)
);

// File: tb/test_pattern_sequencer.sv
// Bench: a behavioural reference is stepped at every rising edge and
// compared with pat_out at the following falling edge.
module test_pattern_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_addr = '0;
    logic [7:0] host_wr_data = '0;
    logic       host_start_wr = 1'b0;
    logic [7:0] host_start_addr = '0;
    logic       host_mode_wr = 1'b0;
    logic       host_mode_ext = 1'b0;
    logic       gen_en = 1'b0;
    logic       ext_clk = 1'b0;
    logic [7:0] pat_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    int mem_m [256];
    int out_m = 0;
    int addr_m = 0;
    int start_m = 0;
    bit run_m = 0;
    bit sel_m = 0;
    bit q1 = 0, q2 = 0, q3 = 0;
    int adv_count = 0;

    always #5 clk = ~clk;

    pattern_sequencer i_pattern_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr_en     (host_wr_en),
        .host_wr_addr   (host_wr_addr),
        .host_wr_data   (host_wr_data),
        .host_start_wr  (host_start_wr),
        .host_start_addr(host_start_addr),
        .host_mode_wr   (host_mode_wr),
        .host_mode_ext  (host_mode_ext),
        .gen_en         (gen_en),
        .ext_clk        (ext_clk),
        .pat_out        (pat_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one clock: update the reference at the edge, compare after.
    task automatic step(input string tag);
        bit tk;
        @(posedge clk);
        if (!rst_n) begin
            out_m = 0; addr_m = 0; run_m = 0; start_m = 0; sel_m = 0;
            q1 = 0; q2 = 0; q3 = 0;
        end else begin
            tk = sel_m ? (q2 && !q3) : 1'b1;
            if (gen_en && !run_m) begin
                addr_m = start_m;
                out_m = mem_m[addr_m];
            end else if (gen_en && tk) begin
                addr_m = (addr_m + 1) % 256;
                out_m = mem_m[addr_m];
                adv_count++;
            end
            run_m = gen_en;
            if (host_wr_en) mem_m[host_wr_addr] = int'(host_wr_data);
            if (host_start_wr) start_m = int'(host_start_addr);
            if (host_mode_wr) sel_m = host_mode_ext;
            q3 = q2; q2 = q1; q1 = ext_clk;
        end
        if (host_wr_en) host_wr_en = host_wr_en;
        @(negedge clk);
        check(tag, int'(pat_out), out_m);
    endtask

    task automatic clear_strobes();
        host_wr_en = 1'b0;
        host_start_wr = 1'b0;
        host_mode_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) step("R1");

        // R2: fill every location while idle (R7: output must stay frozen)
        for (int i = 0; i < 256; i++) begin
            host_wr_en = 1'b1;
            host_wr_addr = 8'(i);
            host_wr_data = 8'((i * 37 + 11) & 255);
            step("R7");
        end
        clear_strobes();

        // R2/R4/R5: walk the full store from address 0 in internal mode
        gen_en = 1'b1;
        for (int i = 0; i < 260; i++) step("R2");
        gen_en = 1'b0;
        for (int i = 0; i < 4; i++) step("R7");

        // R3: start at a programmed address
        host_start_wr = 1'b1; host_start_addr = 8'd10;
        step("R3");
        clear_strobes();
        gen_en = 1'b1;
        for (int i = 0; i < 12; i++) step("R4");
        gen_en = 1'b0;
        // R7: host writes and start writes while idle change nothing visible
        host_wr_en = 1'b1; host_wr_addr = 8'd23; host_wr_data = 8'hA5;
        host_start_wr = 1'b1; host_start_addr = 8'd250;
        step("R7");
        clear_strobes();
        for (int i = 0; i < 3; i++) step("R7");

        // R8: start write in the enable cycle is not used; old value 250 is
        gen_en = 1'b1;
        host_start_wr = 1'b1; host_start_addr = 8'd5;
        step("R8");
        clear_strobes();
        check("R8", int'(pat_out), mem_m[250]);
        // R5: wrap past 255
        for (int i = 0; i < 10; i++) step("R5");
        gen_en = 1'b0;
        step("R7");
        // R8: next enable uses the value 5
        gen_en = 1'b1;
        step("R8");
        check("R8", int'(pat_out), mem_m[5]);

        // R9: write to the location fetched in the same cycle
        for (int i = 0; i < 6; i++) begin
            host_wr_en = 1'b1;
            host_wr_addr = 8'((addr_m + 1) % 256);
            host_wr_data = 8'(8'hF0 + i);
            step("R9");
        end
        clear_strobes();
        gen_en = 1'b0;
        step("R7");
        host_start_wr = 1'b1; host_start_addr = 8'd6;
        step("R7");
        clear_strobes();
        gen_en = 1'b1;
        for (int i = 0; i < 8; i++) step("R9");
        gen_en = 1'b0;
        step("R7");

        // R10: switch to external mode; R6: one advance per rising edge
        host_mode_wr = 1'b1; host_mode_ext = 1'b1;
        step("R10");
        clear_strobes();
        gen_en = 1'b1;
        step("R3");
        adv_count = 0;
        for (int e = 0; e < 8; e++) begin
            ext_clk = 1'b1;
            for (int i = 0; i < 4; i++) step("R6");
            ext_clk = 1'b0;
            for (int i = 0; i < 5; i++) step("R6");
        end
        check("R6", adv_count, 8);
        // R7: external edges while disabled do nothing
        gen_en = 1'b0;
        for (int e = 0; e < 3; e++) begin
            ext_clk = 1'b1;
            for (int i = 0; i < 3; i++) step("R7");
            ext_clk = 1'b0;
            for (int i = 0; i < 3; i++) step("R7");
        end

        // R10: back to internal mode, advance every cycle
        host_mode_wr = 1'b1; host_mode_ext = 1'b0;
        step("R10");
        clear_strobes();
        gen_en = 1'b1;
        for (int i = 0; i < 6; i++) step("R10");

        // R1: reset mid-run clears the output
        rst_n = 1'b0;
        step("R1");
        rst_n = 1'b1;
        gen_en = 1'b0;
        step("R1");
        check("R1", int'(pat_out), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule